// File: doc/BRIEF.md
# Sample-Stream Feeder for a Gapped Serial DAC

This block takes a continuous stream of DAC words from an audio-rate source and drives a serial DAC that accepts one 32-bit frame per conversion. The serial port cannot run as an endless bit stream. Each frame is framed by an active-low select, and the select must meet a setup time, a hold time and a minimum high time. The serial clock therefore runs in bursts that are faster than 32 times the sample rate.

An elastic FIFO sits between the two rates. Incoming words are written whenever `smp_valid` is high. Each pulse of `rate_tick` asks the serializer for one frame. The next tick then pulses the load strobe `ldac_n`, which moves the completed frame into the DAC output. All timing minima are parameters counted in system-clock cycles, rounded up by the integrator.

The serializer is a five-state machine:
- **ST_IDLE**: the select is high and the machine waits for a request. It moves to ST_SETUP when a request is pending, loading the FIFO head or, if the FIFO is empty, the last word sent.
- **ST_SETUP**: the select is low and the clock is high. It moves to ST_SHIFT once the setup count expires.
- **ST_SHIFT**: the machine toggles the clock. It moves to ST_HOLD after the final falling clock edge and its low half-period.
- **ST_HOLD**: the select and the clock are both low. It moves to ST_GAP when the hold count expires, and the select rises at that moment.
- **ST_GAP**: the select and the clock are high. It returns to ST_IDLE when the gap count expires.

Top module: `dac_stream_feeder`

## Requirements
- R1: During and after reset, before any tick, `sync_n`=1, `sclk`=1, `ldac_n`=1, `underflow`=0 and `overflow`=0.
- R2: Every low period of `sync_n` contains exactly 32 falling edges of `sclk`. The word is sent MSB first, and `sdin` is read at each falling edge. `sdin` changes only while `sclk` is high, so it never changes while `sclk` is low.
- R3: At least T_CSS_CYC cycles pass from the fall of `sync_n` to the first falling edge of `sclk`.
- R4: At least T_CSH_CYC cycles pass from the last falling edge of `sclk` to the rise of `sync_n`.
- R5: `sync_n` stays high for at least T_CSHIGH_CYC cycles between frames, and `sclk` is high whenever `sync_n` is high.
- R6: Inside a frame, every high phase and every low phase of `sclk` that is followed by another edge lasts exactly SCLK_HALF cycles.
- R7: Each `rate_tick` produces exactly one frame. Frames carry the written samples in write order.
- R8: A tick pulses `ldac_n` low for LDAC_W cycles, starting the cycle after the tick, if and only if a frame has completed (the select has risen) since the previous pulse. The first tick after reset gives no pulse. `ldac_n` never falls at any other time.
- R9: When a tick finds the FIFO empty, the frame repeats the last word sent (zero after reset). `underflow` then rises and stays high until reset.
- R10: A sample written while the FIFO holds DEPTH (16) words is dropped. `overflow` then rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Write strobe for `smp_data` |
| smp_data | input | 32 | 32-bit word to send to the DAC |
| rate_tick | input | 1 | One-cycle sample-rate tick |
| sclk | output | 1 | Serial clock, idles high |
| sdin | output | 1 | Serial data, MSB first |
| sync_n | output | 1 | Active-low frame select |
| ldac_n | output | 1 | Active-low DAC load pulse |
| underflow | output | 1 | Sticky flag: a tick found the FIFO empty |
| overflow | output | 1 | Sticky flag: a write found the FIFO full |

## Verification
Four distinct words are sent first. They include all-ones, a word with only the MSB and the LSB set, and mixed patterns, so a bit-order slip or a stuck data line shows up in the decoded frame. A tick with the FIFO empty then checks that the previous word is repeated. A burst of seventeen writes with no ticks is drained by seventeen ticks; the final frame must repeat the sixteenth word rather than the seventeenth, which separates a dropped write from a stored one. Every frame is timed edge by edge against the setup, hold, gap and half-period counts, and the load pulse is checked against completed frames on every tick.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } ser_state_e;

endpackage

// File: rtl/dsf_fifo.sv
// Elastic buffer, first word visible at rdata while not empty.
// DEPTH must be a power of two.
module dsf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            if (do_push && !do_pop)      level <= level + (AW+1)'(1);
            else if (do_pop && !do_push) level <= level - (AW+1)'(1);
        end
    end
endmodule

// File: rtl/dsf_serializer.sv
// Burst serializer: one framed W-bit transfer per accepted start.
module dsf_serializer
    import dsf_pkg::*;
#(
    parameter int W            = 32,
    parameter int SCLK_HALF    = 2,
    parameter int T_CSS_CYC    = 4,
    parameter int T_CSH_CYC    = 2,
    parameter int T_CSHIGH_CYC = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    output logic         take,
    output logic         frame_end,
    output logic         sclk,
    output logic         sdin,
    output logic         sync_n
);
    localparam int M1 = (T_CSS_CYC > T_CSH_CYC) ? T_CSS_CYC : T_CSH_CYC;
    localparam int M2 = (T_CSHIGH_CYC > SCLK_HALF) ? T_CSHIGH_CYC : SCLK_HALF;
    localparam int MX = (M1 > M2) ? M1 : M2;
    localparam int CW = $clog2(MX + 1);
    localparam int BW = $clog2(W);

    ser_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bits_left;
    logic [W-1:0]  sh;
    logic          lo;
    logic          cnt_done;

    assign cnt_done  = (cnt == '0);
    assign take      = (state == ST_IDLE) && start;
    assign frame_end = (state == ST_HOLD) && cnt_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)    nxt = ST_SETUP;
            ST_SETUP: if (cnt_done) nxt = ST_SHIFT;
            ST_SHIFT: if (lo && cnt_done && bits_left == '0) nxt = ST_HOLD;
            ST_HOLD:  if (cnt_done) nxt = ST_GAP;
            ST_GAP:   if (cnt_done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bits_left <= '0;
            sh        <= '0;
            lo        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    sh  <= word;
                    cnt <= CW'(T_CSS_CYC - 1);
                end
                ST_SETUP: if (cnt_done) begin
                    lo        <= 1'b1;
                    cnt       <= CW'(SCLK_HALF - 1);
                    bits_left <= BW'(W - 1);
                end else cnt <= cnt - CW'(1);
                ST_SHIFT: if (!cnt_done) cnt <= cnt - CW'(1);
                else if (lo) begin
                    if (bits_left == '0) cnt <= CW'(T_CSH_CYC - 1);
                    else begin
                        lo        <= 1'b0;
                        sh        <= {sh[W-2:0], 1'b0};
                        bits_left <= bits_left - BW'(1);
                        cnt       <= CW'(SCLK_HALF - 1);
                    end
                end else begin
                    lo  <= 1'b1;
                    cnt <= CW'(SCLK_HALF - 1);
                end
                ST_HOLD: if (cnt_done) cnt <= CW'(T_CSHIGH_CYC - 1);
                         else          cnt <= cnt - CW'(1);
                ST_GAP:  if (!cnt_done) cnt <= cnt - CW'(1);
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sync_n = (state == ST_IDLE) || (state == ST_GAP);
        sclk   = !(((state == ST_SHIFT) && lo) || (state == ST_HOLD));
        sdin   = sh[W-1];
    end
endmodule

// File: rtl/dsf_ldac_ctl.sv
// Load strobe: a tick fires a pulse only if a frame has completed since the last one.
module dsf_ldac_ctl #(
    parameter int LDAC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic frame_end,
    output logic ldac_n
);
    localparam int LW = $clog2(LDAC_W + 1);

    logic          pending;
    logic [LW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            pcnt    <= '0;
        end else begin
            if (tick && pending)  pcnt <= LW'(LDAC_W);
            else if (pcnt != '0)  pcnt <= pcnt - LW'(1);
            if (frame_end)        pending <= 1'b1;
            else if (tick)        pending <= 1'b0;
        end
    end

    assign ldac_n = (pcnt == '0);
endmodule

// File: rtl/dac_stream_feeder.sv
module dac_stream_feeder #(
    parameter int DATA_W       = 32,
    parameter int DEPTH        = 16,
    parameter int SCLK_HALF    = 2,
    parameter int T_CSS_CYC    = 4,
    parameter int T_CSH_CYC    = 2,
    parameter int T_CSHIGH_CYC = 10,
    parameter int LDAC_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              rate_tick,
    output logic              sclk,
    output logic              sdin,
    output logic              sync_n,
    output logic              ldac_n,
    output logic              underflow,
    output logic              overflow
);
    logic [DATA_W-1:0] head, last, word;
    logic              empty, full, take, frame_end, req;

    dsf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(smp_valid), .wdata(smp_data),
        .pop(take), .rdata(head),
        .empty(empty), .full(full)
    );

    assign word = empty ? last : head;

    dsf_serializer #(
        .W(DATA_W), .SCLK_HALF(SCLK_HALF), .T_CSS_CYC(T_CSS_CYC),
        .T_CSH_CYC(T_CSH_CYC), .T_CSHIGH_CYC(T_CSHIGH_CYC)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .start(req), .word(word),
        .take(take), .frame_end(frame_end),
        .sclk(sclk), .sdin(sdin), .sync_n(sync_n)
    );

    dsf_ldac_ctl #(.LDAC_W(LDAC_W)) u_ldac (
        .clk(clk), .rst_n(rst_n), .tick(rate_tick),
        .frame_end(frame_end), .ldac_n(ldac_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req       <= 1'b0;
            last      <= '0;
            underflow <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            req <= rate_tick || (req && !take);
            if (take)              last      <= word;
            if (take && empty)     underflow <= 1'b1;
            if (smp_valid && full) overflow  <= 1'b1;
        end
    end
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdin,
    input logic sync_n,
    input logic underflow,
    input logic overflow
);
    localparam int FW = $clog2(W + 2);
    logic [FW-1:0] falls;
    logic          sclk_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls  <= '0;
            sclk_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            sync_q <= sync_n;
            if (!sync_n && sync_q)      falls <= '0;
            else if (!sclk && sclk_q)   falls <= falls + FW'(1);
        end
    end

    // R5
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> sclk);

    // R2
    sdin_stable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> $stable(sdin));

    // R2
    fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && !sync_q) |-> (falls == FW'(W)));

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind dac_stream_feeder dsf_checker #(.W(DATA_W)) u_dsf_checker (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
    .sync_n(sync_n), .underflow(underflow), .overflow(overflow)
);

// File: tb/test_dac_stream_feeder.sv
module test_dac_stream_feeder;
    localparam int W = 32, DEPTH = 16, HALF = 2, CSS = 4, CSH = 2, CSHIGH = 10, LW = 2;

    logic clk = 0, rst_n = 0, smp_valid = 0, rate_tick = 0;
    logic [W-1:0] smp_data = '0;
    logic sclk, sdin, sync_n, ldac_n, underflow, overflow;

    always #5 clk = ~clk;

    dac_stream_feeder i_dac_stream_feeder (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rate_tick(rate_tick), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
        .ldac_n(ldac_n), .underflow(underflow), .overflow(overflow)
    );

    int checks = 0, fails = 0;
    int frames_seen = 0, ldac_done = 0, ldac_falls = 0;
    logic [W-1:0] model_q[$], exp_word[$];
    string exp_tag[$];
    logic [W-1:0] last_m = '0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: decodes frames, times edges, pops the scoreboard
    logic ps = 1, pk = 1, pd = 0, pl = 1;
    int hi_cnt = 100, css_cnt = 0, since_fall = 0, phase = 0, nfall = 0;
    bit stab_err = 0;
    logic [W-1:0] got = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ldac_n && pl) ldac_falls++;
            if (sync_n && !sclk) stab_err = 1;                 // R5 clock idle
            if (!sync_n && ps) begin                           // select falls
                check(hi_cnt >= CSHIGH, "R5 gap", hi_cnt, CSHIGH);
                css_cnt = 0; nfall = 0; got = '0; phase = 0;
            end else if (!sync_n) begin
                css_cnt++; since_fall++; phase++;
                if (!sclk && pk) begin                         // falling edge
                    if (nfall == 0) check(css_cnt >= CSS, "R3 setup", css_cnt, CSS);
                    else check(phase == HALF, "R6 high phase", phase, HALF);
                    got = {got[W-2:0], sdin};
                    nfall++; since_fall = 0; phase = 0;
                end else if (sclk && !pk) begin                // rising edge
                    check(phase == HALF, "R6 low phase", phase, HALF);
                    phase = 0;
                end
                if (!sclk && sdin != pd) stab_err = 1;
            end
            if (sync_n && !ps) begin                           // select rises
                since_fall++;
                check(nfall == W, "R2 edge count", nfall, W);
                check(since_fall >= CSH, "R4 hold", since_fall, CSH);
                check(!stab_err, "R2/R5 sdin stable, clock idle high", stab_err, 0);
                stab_err = 0;
                if (exp_word.size() == 0) check(0, "R7 unexpected frame", got, 0);
                else begin
                    automatic logic [W-1:0] e = exp_word.pop_front();
                    automatic string t = exp_tag.pop_front();
                    check(got == e, t, got, e);
                end
                frames_seen++;
                hi_cnt = 0;
            end
            if (sync_n) hi_cnt++;
        end
        ps = sync_n; pk = sclk; pd = sdin; pl = ldac_n;
    end

    // driver
    task automatic push_sample(input logic [W-1:0] d);
        @(negedge clk); smp_valid = 1; smp_data = d;
        @(negedge clk); smp_valid = 0;
        if (model_q.size() < DEPTH) model_q.push_back(d);
    endtask

    task automatic tick(input string tag);
        automatic logic [W-1:0] e;
        automatic bit exp_l = (frames_seen > ldac_done);
        if (model_q.size() > 0) e = model_q.pop_front();
        else e = last_m;
        last_m = e;
        exp_word.push_back(e); exp_tag.push_back(tag);
        @(negedge clk); rate_tick = 1;
        @(negedge clk); rate_tick = 0;
        check(ldac_n == !exp_l, "R8 pulse start", ldac_n, !exp_l);
        if (exp_l) begin
            for (int i = 1; i < LW; i++) begin
                @(negedge clk);
                check(ldac_n == 0, "R8 pulse width", ldac_n, 0);
            end
            @(negedge clk);
            check(ldac_n == 1, "R8 pulse end", ldac_n, 1);
            ldac_done++;
        end
        repeat (200) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sync_n == 1 && sclk == 1 && ldac_n == 1, "R1 in reset", {sync_n, sclk, ldac_n}, 3'b111);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(sync_n == 1, "R1 sync_n", sync_n, 1);
        check(sclk == 1, "R1 sclk", sclk, 1);
        check(ldac_n == 1, "R1 ldac_n", ldac_n, 1);
        check(underflow == 0 && overflow == 0, "R1 flags", {underflow, overflow}, 0);

        // distinct patterns, write order
        push_sample(32'hA5C3_0F1E);
        push_sample(32'h8000_0001);
        push_sample(32'hFFFF_FFFF);
        push_sample(32'h1357_9BDF);
        for (int i = 0; i < 4; i++) tick("R7 frame data");
        check(underflow == 0, "R9 no underflow yet", underflow, 0);

        // empty FIFO: repeat last word
        tick("R9 repeat on empty");
        check(underflow == 1, "R9 flag set", underflow, 1);

        // overflow: 17 writes, 17th dropped
        check(overflow == 0, "R10 no overflow yet", overflow, 0);
        for (int i = 0; i < DEPTH + 1; i++) push_sample(32'h5A00_0000 ^ (i * 32'h0102_0305));
        check(overflow == 1, "R10 flag set", overflow, 1);
        for (int i = 0; i < DEPTH; i++) tick("R10 kept words");
        tick("R10 dropped word not sent");
        check(underflow == 1 && overflow == 1, "R9 R10 flags sticky", {underflow, overflow}, 2'b11);

        repeat (300) @(negedge clk);
        check(exp_word.size() == 0, "R7 one frame per tick", exp_word.size(), 0);
        check(ldac_falls == ldac_done, "R8 no stray pulses", ldac_falls, ldac_done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule